// File: doc/BRIEF.md
# PWM Output Action Qualifier

This block sets the logic level of two pulse-width outputs, A and B, from events reported by a counter and compare stage. There are four events: the counter reached zero, the counter reached its period, the counter matched compare value A, and the counter matched compare value B. The count direction comes with them. Each output has its own configuration word. The word holds a two-bit action code for zero, for period, and for each compare match in each direction. An action can leave the output as it is, drive it low, drive it high, or invert it.

Several events can land in the same cycle. When they do, a fixed priority picks the one action that applies, and the count mode chooses that priority. Software can also act on each output in two ways. A one-cycle force strobe applies an action code once. A continuous override holds the output high or low for as long as it is set. The counter and the compare logic sit outside this block and drive its event inputs.

Top module: `pwm_aq`

## Requirements
- R1: While `rst_n` is low, `pwm_a` is at parameter `RST_LVL_A` and `pwm_b` is at parameter `RST_LVL_B`.
- R2: Action codes are 00 hold, 01 drive low, 10 drive high and 11 invert. The output register takes the resolved action at the first rising clock edge that samples the event.
- R3: Each configuration word (`cfg_a`, `cfg_b`) holds these fields: bits [1:0] zero, [3:2] period, [5:4] compare A counting up, [7:6] compare A counting down, [9:8] compare B counting up, [11:10] compare B counting down.
- R4: A compare match uses its up field when `cnt_up` is 1 and its down field when `cnt_up` is 0.
- R5: Output A depends only on `cfg_a`, `frc_a_*` and `ovr_a`. Output B depends only on `cfg_b`, `frc_b_*` and `ovr_b`.
- R6: With `cnt_mode` 00 (count up), the priority from highest to lowest is period, compare B, compare A, zero.
- R7: With `cnt_mode` 01 (count down), the priority from highest to lowest is zero, compare B, compare A, period.
- R8: With `cnt_mode` 10 or 11 (count up-down), the priority from highest to lowest is compare B, compare A, zero, period.
- R9: During resolution, an event that is present but whose action code is 00 is skipped, and the next event in priority order decides.
- R10: When a force strobe carries a nonzero code, that code is applied once in place of any event action in the same cycle. A strobe with code 00 leaves event handling unchanged.
- R11: Override code 01 holds the output low and code 10 holds it high. Both win over forces and events. Override codes 00 and 11 are inactive.
- R12: When no event is present, no force is strobed and no override is active, the output keeps its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_mode | input | 2 | Count mode: 00 up, 01 down, 10/11 up-down |
| cnt_up | input | 1 | Current count direction, 1 = up |
| evt_zero | input | 1 | Counter equals zero |
| evt_prd | input | 1 | Counter equals period |
| evt_cmpa | input | 1 | Counter equals compare A |
| evt_cmpb | input | 1 | Counter equals compare B |
| cfg_a | input | 12 | Event action word for output A |
| cfg_b | input | 12 | Event action word for output B |
| frc_a_stb | input | 1 | One-time force strobe, output A |
| frc_a_code | input | 2 | Action applied by the A strobe |
| frc_b_stb | input | 1 | One-time force strobe, output B |
| frc_b_code | input | 2 | Action applied by the B strobe |
| ovr_a | input | 2 | Continuous override, output A |
| ovr_b | input | 2 | Continuous override, output B |
| pwm_a | output | 1 | Output A level |
| pwm_b | output | 1 | Output B level |

## Verification
The bench builds the block with `RST_LVL_A` = 0 and `RST_LVL_B` = 1. Because the two reset levels differ, one reset check sees both parameters, and a channel wired to the wrong parameter or to the other channel shows up at once. The differing levels also put A and B at opposite starting points, so the same invert action drives them in opposite directions and cross-channel mix-ups become visible. A long stretch of mixed events, modes, forces and overrides then runs against the behavioural model on every cycle, which reaches all the priority collisions.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;

    localparam int AQ_ACT_W  = 2;
    localparam int AQ_NFIELD = 6;
    localparam int AQ_CFG_W  = AQ_ACT_W * AQ_NFIELD;
    localparam int AQ_NSLOT  = 4;

    typedef enum logic [AQ_ACT_W-1:0] {
        ACT_HOLD = 2'b00,
        ACT_LOW  = 2'b01,
        ACT_HIGH = 2'b10,
        ACT_INV  = 2'b11
    } aq_act_e;

    typedef enum logic [1:0] {
        MODE_UP   = 2'b00,
        MODE_DOWN = 2'b01,
        MODE_UPDN = 2'b10,
        MODE_UPDN2 = 2'b11
    } aq_mode_e;

    typedef struct packed {
        logic zero;
        logic prd;
        logic cmpa;
        logic cmpb;
    } aq_evt_t;

    function automatic logic aq_apply(input logic cur, input logic [AQ_ACT_W-1:0] act);
        case (act)
            ACT_LOW:  return 1'b0;
            ACT_HIGH: return 1'b1;
            ACT_INV:  return ~cur;
            default:  return cur;
        endcase
    endfunction

endpackage

// File: rtl/pwm_aq_resolve.sv
module pwm_aq_resolve
    import pwm_aq_pkg::*;
(
    input  logic [1:0]          mode,
    input  logic                dir_up,
    input  aq_evt_t             evt,
    input  logic [AQ_CFG_W-1:0] cfg,
    output logic [AQ_ACT_W-1:0] act
);

    logic [AQ_ACT_W-1:0] c_zero, c_prd, c_cmpa, c_cmpb;
    logic [AQ_ACT_W-1:0] slot [AQ_NSLOT];

    always_comb begin
        c_zero = evt.zero ? cfg[1:0] : ACT_HOLD;
        c_prd  = evt.prd  ? cfg[3:2] : ACT_HOLD;
        c_cmpa = evt.cmpa ? (dir_up ? cfg[5:4] : cfg[7:6])   : ACT_HOLD;
        c_cmpb = evt.cmpb ? (dir_up ? cfg[9:8] : cfg[11:10]) : ACT_HOLD;

        // slot 0 carries the highest priority
        case (mode)
            MODE_UP: begin
                slot[0] = c_prd;  slot[1] = c_cmpb; slot[2] = c_cmpa; slot[3] = c_zero;
            end
            MODE_DOWN: begin
                slot[0] = c_zero; slot[1] = c_cmpb; slot[2] = c_cmpa; slot[3] = c_prd;
            end
            default: begin
                slot[0] = c_cmpb; slot[1] = c_cmpa; slot[2] = c_zero; slot[3] = c_prd;
            end
        endcase

        act = ACT_HOLD;
        for (int i = AQ_NSLOT - 1; i >= 0; i--) begin
            if (slot[i] != ACT_HOLD) act = slot[i];
        end
    end

endmodule

// File: rtl/pwm_aq_channel.sv
module pwm_aq_channel
    import pwm_aq_pkg::*;
#(
    parameter logic RST_LVL = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [AQ_ACT_W-1:0] evt_act,
    input  logic                frc_stb,
    input  logic [AQ_ACT_W-1:0] frc_code,
    input  logic [1:0]          ovr,
    output logic                lvl
);

    typedef struct packed {
        logic lvl;
    } ch_state_t;

    ch_state_t           st_d, st_q;
    logic [AQ_ACT_W-1:0] eff_act;

    always_comb begin
        eff_act = evt_act;
        if (frc_stb && frc_code != ACT_HOLD) eff_act = frc_code;

        st_d = st_q;
        case (ovr)
            2'b01:   st_d.lvl = 1'b0;
            2'b10:   st_d.lvl = 1'b1;
            default: st_d.lvl = aq_apply(st_q.lvl, eff_act);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{lvl: RST_LVL};
        else        st_q <= st_d;
    end

    assign lvl = st_q.lvl;

endmodule

// File: rtl/pwm_aq.sv
module pwm_aq
    import pwm_aq_pkg::*;
#(
    parameter logic RST_LVL_A = 1'b0,
    parameter logic RST_LVL_B = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          cnt_mode,
    input  logic                cnt_up,
    input  logic                evt_zero,
    input  logic                evt_prd,
    input  logic                evt_cmpa,
    input  logic                evt_cmpb,
    input  logic [AQ_CFG_W-1:0] cfg_a,
    input  logic [AQ_CFG_W-1:0] cfg_b,
    input  logic                frc_a_stb,
    input  logic [AQ_ACT_W-1:0] frc_a_code,
    input  logic                frc_b_stb,
    input  logic [AQ_ACT_W-1:0] frc_b_code,
    input  logic [1:0]          ovr_a,
    input  logic [1:0]          ovr_b,
    output logic                pwm_a,
    output logic                pwm_b
);

    localparam int NUM_CH = 2;
    localparam logic [NUM_CH-1:0] RST_VEC = {RST_LVL_B, RST_LVL_A};

    aq_evt_t             evt;
    logic [AQ_CFG_W-1:0] cfg_v  [NUM_CH];
    logic                fstb_v [NUM_CH];
    logic [AQ_ACT_W-1:0] fcode_v[NUM_CH];
    logic [1:0]          ovr_v  [NUM_CH];
    logic [AQ_ACT_W-1:0] act_v  [NUM_CH];
    logic [NUM_CH-1:0]   lvl_v;

    assign evt = '{zero: evt_zero, prd: evt_prd, cmpa: evt_cmpa, cmpb: evt_cmpb};

    assign cfg_v[0]   = cfg_a;      assign cfg_v[1]   = cfg_b;
    assign fstb_v[0]  = frc_a_stb;  assign fstb_v[1]  = frc_b_stb;
    assign fcode_v[0] = frc_a_code; assign fcode_v[1] = frc_b_code;
    assign ovr_v[0]   = ovr_a;      assign ovr_v[1]   = ovr_b;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        pwm_aq_resolve u_res (
            .mode   (cnt_mode),
            .dir_up (cnt_up),
            .evt    (evt),
            .cfg    (cfg_v[ch]),
            .act    (act_v[ch])
        );

        pwm_aq_channel #(.RST_LVL(RST_VEC[ch])) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt_act  (act_v[ch]),
            .frc_stb  (fstb_v[ch]),
            .frc_code (fcode_v[ch]),
            .ovr      (ovr_v[ch]),
            .lvl      (lvl_v[ch])
        );
    end

    assign pwm_a = lvl_v[0];
    assign pwm_b = lvl_v[1];

endmodule

// File: rtl/pwm_aq_chk.sv
module pwm_aq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       evt_zero,
    input logic       evt_prd,
    input logic       evt_cmpa,
    input logic       evt_cmpb,
    input logic       frc_a_stb,
    input logic [1:0] frc_a_code,
    input logic [1:0] ovr_a,
    input logic [1:0] ovr_b,
    input logic       pwm_a,
    input logic       pwm_b
);

    logic any_evt, ovr_a_off;
    assign any_evt   = evt_zero | evt_prd | evt_cmpa | evt_cmpb;
    assign ovr_a_off = (ovr_a == 2'b00) || (ovr_a == 2'b11);

    a_r11_ovr_high_a: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_a == 2'b10 |=> pwm_a);

    a_r11_ovr_low_b: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_b == 2'b01 |=> !pwm_b);

    a_r12_hold_a: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_evt && !frc_a_stb && ovr_a_off) |=> $stable(pwm_a));

    a_r10_frc_inv_a: assert property (@(posedge clk) disable iff (!rst_n)
        (frc_a_stb && frc_a_code == 2'b11 && ovr_a_off) |=> pwm_a != $past(pwm_a));

endmodule

bind pwm_aq pwm_aq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_zero   (evt_zero),
    .evt_prd    (evt_prd),
    .evt_cmpa   (evt_cmpa),
    .evt_cmpb   (evt_cmpb),
    .frc_a_stb  (frc_a_stb),
    .frc_a_code (frc_a_code),
    .ovr_a      (ovr_a),
    .ovr_b      (ovr_b),
    .pwm_a      (pwm_a),
    .pwm_b      (pwm_b)
);

// File: tb/pwm_aq_tb.sv
module pwm_aq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cnt_mode = 2'b00;
    logic        cnt_up = 1'b1;
    logic        evt_zero = 0, evt_prd = 0, evt_cmpa = 0, evt_cmpb = 0;
    logic [11:0] cfg_a = '0, cfg_b = '0;
    logic        frc_a_stb = 0, frc_b_stb = 0;
    logic [1:0]  frc_a_code = 0, frc_b_code = 0;
    logic [1:0]  ovr_a = 0, ovr_b = 0;
    logic        pwm_a, pwm_b;

    int  checks = 0;
    int  errors = 0;
    bit  exp_a, exp_b;
    bit  done = 0;

    always #4 clk = ~clk;

    pwm_aq #(.RST_LVL_A(1'b0), .RST_LVL_B(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_mode(cnt_mode), .cnt_up(cnt_up),
        .evt_zero(evt_zero), .evt_prd(evt_prd), .evt_cmpa(evt_cmpa), .evt_cmpb(evt_cmpb),
        .cfg_a(cfg_a), .cfg_b(cfg_b),
        .frc_a_stb(frc_a_stb), .frc_a_code(frc_a_code),
        .frc_b_stb(frc_b_stb), .frc_b_code(frc_b_code),
        .ovr_a(ovr_a), .ovr_b(ovr_b), .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    // action code of event id (0 zero, 1 period, 2 compare A, 3 compare B)
    function automatic bit [1:0] code_of(int id, bit [11:0] cfg, bit up);
        int base;
        case (id)
            0: base = 0;
            1: base = 2;
            2: base = up ? 4 : 6;
            default: base = up ? 8 : 10;
        endcase
        return {cfg[base+1], cfg[base]};
    endfunction

    function automatic bit model(bit cur, bit [11:0] cfg, bit fs, bit [1:0] fc, bit [1:0] ov);
        int  order[4];
        bit  present[4];
        bit [1:0] act = 2'b00;
        present[0] = evt_zero; present[1] = evt_prd;
        present[2] = evt_cmpa; present[3] = evt_cmpb;
        if (cnt_mode == 2'b00)      order = '{1, 3, 2, 0};
        else if (cnt_mode == 2'b01) order = '{0, 3, 2, 1};
        else                        order = '{3, 2, 0, 1};
        foreach (order[k]) begin
            if (act == 2'b00 && present[order[k]])
                act = code_of(order[k], cfg, cnt_up);
        end
        if (fs && fc != 2'b00) act = fc;
        if (ov == 2'b01) return 1'b0;
        if (ov == 2'b10) return 1'b1;
        case (act)
            2'b01:   return 1'b0;
            2'b10:   return 1'b1;
            2'b11:   return ~cur;
            default: return cur;
        endcase
    endfunction

    task automatic check(string tag);
        checks += 2;
        if (pwm_a !== exp_a) begin
            errors++;
            $display("FAIL %s pwm_a actual=%b expected=%b", tag, pwm_a, exp_a);
        end
        if (pwm_b !== exp_b) begin
            errors++;
            $display("FAIL %s pwm_b actual=%b expected=%b", tag, pwm_b, exp_b);
        end
    endtask

    // inputs already set at a falling edge; advance one clock and compare
    task automatic tick(string tag);
        @(posedge clk);
        #1;
        exp_a = model(exp_a, cfg_a, frc_a_stb, frc_a_code, ovr_a);
        exp_b = model(exp_b, cfg_b, frc_b_stb, frc_b_code, ovr_b);
        @(negedge clk);
        check(tag);
    endtask

    task automatic idle();
        {evt_zero, evt_prd, evt_cmpa, evt_cmpb} = 4'b0000;
        frc_a_stb = 0; frc_b_stb = 0; ovr_a = 0; ovr_b = 0;
    endtask

    task automatic set_ev(bit z, bit p, bit a, bit b);
        evt_zero = z; evt_prd = p; evt_cmpa = a; evt_cmpb = b;
    endtask

    task automatic hard(string tag, bit ea, bit eb);
        checks++;
        if (pwm_a !== ea || pwm_b !== eb) begin
            errors++;
            $display("FAIL %s actual=%b%b expected=%b%b", tag, pwm_a, pwm_b, ea, eb);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        exp_a = 1'b0; exp_b = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset levels");
        rst_n = 1'b1;

        // R2: each code on the zero event
        cfg_a = 12'h002; cfg_b = 12'h001; set_ev(1,0,0,0); tick("R2 high/low");
        hard("R2 high/low hard", 1'b1, 1'b0);
        cfg_a = 12'h003; cfg_b = 12'h003; tick("R2 invert");
        hard("R2 invert hard", 1'b0, 1'b1);
        cfg_a = 12'h000; cfg_b = 12'h000; tick("R2 hold");
        idle(); tick("R12 idle"); tick("R12 idle");

        // R3: each field position on its own
        for (int f = 0; f < 6; f++) begin
            cfg_a = 12'(2'b11 << (2*f)); cfg_b = 12'(2'b10 << (2*f));
            cnt_mode = 2'b10;
            cnt_up = (f == 2 || f == 4);
            set_ev(f == 0, f == 1, f == 2 || f == 3, f == 4 || f == 5);
            tick("R3 field position");
        end
        idle();

        // R4: direction qualification of compare A
        cfg_a = 12'b0000_0110_0000; cfg_b = 12'b0000_1001_0000;
        cnt_up = 1; set_ev(0,0,1,0); tick("R4 compare up");
        hard("R4 compare up hard", 1'b1, 1'b0);
        cnt_up = 0; tick("R4 compare down");
        hard("R4 compare down hard", 1'b0, 1'b1);
        idle();

        // R5: independent channels
        cfg_a = 12'h002; cfg_b = 12'h003; set_ev(1,0,0,0);
        ovr_b = 2'b01; tick("R5 independent");
        ovr_b = 2'b00; frc_a_stb = 1; frc_a_code = 2'b01; tick("R5 independent force");
        idle();

        // R6/R7/R8: all events at once, distinct codes per event
        // zero=01 prd=10 cmpa(up/dn)=11 cmpb(up/dn)=01/10
        cfg_a = 12'b10_01_11_11_10_01;
        cfg_b = 12'b01_10_11_11_01_10;
        for (int m = 0; m < 4; m++) begin
            cnt_mode = 2'(m);
            for (int d = 0; d < 2; d++) begin
                cnt_up = d[0];
                set_ev(1,1,1,1);
                tick(m == 0 ? "R6 up priority" : (m == 1 ? "R7 down priority" : "R8 updown priority"));
                set_ev(1,1,1,0);
                tick(m == 0 ? "R6 up priority" : (m == 1 ? "R7 down priority" : "R8 updown priority"));
                set_ev(1,0,1,0);
                tick(m == 0 ? "R6 up priority" : (m == 1 ? "R7 down priority" : "R8 updown priority"));
            end
        end
        idle();

        // R9: highest present event has code 00
        cnt_mode = 2'b10; cnt_up = 1;
        cfg_a = 12'b00_00_00_11_00_10; cfg_b = 12'b00_00_00_00_00_01;
        set_ev(1,0,1,1); tick("R9 skip hold code");
        set_ev(1,0,1,1); tick("R9 skip hold code");
        idle();

        // R10: one-time force over events
        cfg_a = 12'h002; cfg_b = 12'h002; set_ev(1,0,0,0);
        frc_a_stb = 1; frc_a_code = 2'b01; frc_b_stb = 1; frc_b_code = 2'b00;
        tick("R10 force over event");
        hard("R10 force over event hard", 1'b0, 1'b1);
        idle(); frc_a_stb = 1; frc_a_code = 2'b11; tick("R10 force invert");
        idle(); tick("R10 force once");

        // R11: continuous override
        cfg_a = 12'h003; cfg_b = 12'h003; set_ev(1,0,0,0);
        ovr_a = 2'b10; ovr_b = 2'b01; frc_a_stb = 1; frc_a_code = 2'b01;
        tick("R11 override"); tick("R11 override hold");
        hard("R11 override hard", 1'b1, 1'b0);
        frc_a_stb = 0; ovr_a = 2'b11; ovr_b = 2'b00; tick("R11 inactive codes");
        idle();

        // mixed traffic against the model
        for (int n = 0; n < 3000; n++) begin
            cnt_mode = 2'($urandom_range(0, 3));
            cnt_up = 1'($urandom_range(0, 1));
            set_ev($urandom_range(0,2) == 0, $urandom_range(0,3) == 0,
                   $urandom_range(0,2) == 0, $urandom_range(0,2) == 0);
            if (n % 64 == 0) begin
                cfg_a = 12'($urandom); cfg_b = 12'($urandom);
            end
            frc_a_stb = ($urandom_range(0, 9) == 0); frc_a_code = 2'($urandom);
            frc_b_stb = ($urandom_range(0, 9) == 0); frc_b_code = 2'($urandom);
            ovr_a = ($urandom_range(0, 7) == 0) ? 2'($urandom) : 2'b00;
            ovr_b = ($urandom_range(0, 7) == 0) ? 2'($urandom) : 2'b00;
            tick("R8 R10 R11 mixed");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule